// File: doc/BRIEF.md
# Prefixed 8-bit Load Execution Unit

This unit steps through a program one byte at a time over a synchronous byte-wide memory port. It executes only the 8-bit load group of a classic accumulator machine. It holds seven 8-bit working registers and two 16-bit index bases. It moves bytes between registers, loads immediates, and reads memory at the address formed by the H and L registers. With a one-byte prefix, it reads memory at an index base plus a signed displacement. It can also store a register to the H:L address. Every other opcode stops the unit and raises an illegal flag, and a dedicated opcode stops it without error.

Each instruction byte is fetched in two cycles. In the first cycle the address is driven. In the second cycle the returned byte is consumed, because read data is valid one cycle after its address. A memory read takes two cycles and a store takes one write cycle. The resulting instruction lengths are:

| Instruction | Cycles |
|---|---|
| Register move | 2 |
| Immediate load | 4 |
| H:L read | 4 |
| H:L store | 3 |
| Indexed read | 8 |

The register contents are visible on a flat debug output so that a test environment can follow them.

Top module: `ld8_exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following hold: the program counter returns to 0x0000, all seven registers become 0x00, `halted`, `illegal` and `mem_we` are 0, and the index bases take their parameter values IX_RST and IY_RST.
- R2: Registers use 3-bit codes B=000, C=001, D=010, E=011, H=100, L=101, A=111. Slot 110 in `dbg_regs` always reads 0x00. An opcode 01 ddd sss with neither field 110 copies register sss into register ddd at the end of its second cycle.
- R3: An opcode 00 ddd 110 with ddd not 110 takes the next byte as an unsigned immediate. It writes that byte into register ddd at the end of the fourth cycle.
- R4: An opcode 01 ddd 110 with ddd not 110, and no prefix, reads memory at address {H,L}. The byte is written into register ddd at the end of the fourth cycle.
- R5: An opcode 01110 sss with sss not 110 drives `mem_we` high for exactly one cycle, its third. In that cycle `mem_addr` is {H,L} and `mem_wdata` is register sss. No register changes. `mem_we` is never high at any other time.
- R6: Prefix 0xDD selects base IX and prefix 0xFD selects base IY. The prefix is followed by 01 ddd 110 (ddd not 110) and then a displacement byte. Register ddd then receives the byte at base plus the sign-extended displacement, modulo 2^16, at the end of the eighth cycle.
- R7: Opcode 0x76 sets `halted` at the end of its second cycle. From then on `halted` stays 1, the program counter does not move, and no memory write occurs.
- R8: The following opcodes set both `illegal` and `halted` at the end of the cycle that consumes them: any opcode without a prefix not covered by R2 to R7, and any byte after a prefix other than the R6 opcode form (including another prefix and 0x76).
- R9: The program counter rises by exactly one at the end of each cycle that consumes an instruction byte. This includes prefix, displacement, immediate, halt and illegal bytes, and happens at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address for fetch, read or write |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Write strobe for the current address |
| halted | output | 1 | Unit has stopped |
| illegal | output | 1 | Stop was caused by an unsupported byte |
| pc_out | output | 16 | Current program counter |
| dbg_regs | output | 64 | Register slot k in bits 8k+7:8k |

## Verification
Two functions can fall into the same cycle. In the first case, a register written by one instruction is used by the very next instruction as the memory address. The bench provokes this with immediate loads into H and L directly before an H:L read. It also uses a read that overwrites H and is followed by another H:L read. In the second case, the register being stored is itself part of the address, as when storing H or L to {H,L}. Both cases are judged by a behavioural reference model that tracks the registers, the counter and the expected write strobe, address and data on every clock. A stale address or stale data shows up as a mismatch in the cycle it occurs.

// File: rtl/ld8_pkg.sv
// Shared constants and types for the 8-bit load execution unit.
// Assumes 3-bit register select fields and 8-bit opcodes.
package ld8_pkg;
    localparam int          RSEL_W   = 3;
    localparam int          NSLOT    = 1 << RSEL_W;
    localparam logic [2:0]  CODE_H   = 3'b100;
    localparam logic [2:0]  CODE_L   = 3'b101;
    localparam logic [2:0]  CODE_MEM = 3'b110;
    localparam logic [7:0]  PFX_X    = 8'hDD;
    localparam logic [7:0]  PFX_Y    = 8'hFD;

    typedef enum logic [2:0] {
        ST_OP, ST_DISP, ST_IMM, ST_RD, ST_WR, ST_HALT
    } fsm_t;

    typedef enum logic [3:0] {
        K_BAD, K_PFX_X, K_PFX_Y, K_MOVE, K_IMM, K_LDHL, K_STHL, K_HALT, K_IDX
    } kind_t;
endpackage

// File: rtl/ld8_decode.sv
// Opcode classifier: maps one opcode byte plus the prefix-pending flag to an
// instruction kind and its destination/source register fields.
// Assumes the caller only acts on the result in the byte-consume cycle.
module ld8_decode
    import ld8_pkg::*;
(
    input  logic [7:0] op,
    input  logic       pfx_on,
    output kind_t      kind,
    output logic [2:0] dst,
    output logic [2:0] src
);
    logic [1:0] grp;

    assign grp = op[7:6];
    assign dst = op[5:3];
    assign src = op[2:0];

    // Classify the byte; after a prefix only the indexed-read form is legal.
    always_comb begin
        kind = K_BAD;
        if (pfx_on) begin
            if (grp == 2'b01 && src == CODE_MEM && dst != CODE_MEM)
                kind = K_IDX;
        end else if (op == PFX_X) begin
            kind = K_PFX_X;
        end else if (op == PFX_Y) begin
            kind = K_PFX_Y;
        end else if (grp == 2'b01) begin
            if (dst == CODE_MEM && src == CODE_MEM)
                kind = K_HALT;
            else if (dst == CODE_MEM)
                kind = K_STHL;
            else if (src == CODE_MEM)
                kind = K_LDHL;
            else
                kind = K_MOVE;
        end else if (grp == 2'b00 && src == CODE_MEM && dst != CODE_MEM) begin
            kind = K_IMM;
        end
    end
endmodule

// File: rtl/ld8_regfile.sv
// Working register file: one slot per 3-bit code, with the memory code slot
// tied to zero. One write port, one read port, an H:L pair output and a
// flat debug view. Assumes the writer never selects the memory code.
module ld8_regfile
    import ld8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RSEL_W-1:0]  wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic [RSEL_W-1:0]  rd_sel,
    output logic [DW-1:0]      rd_data,
    output logic [2*DW-1:0]    hl,
    output logic [NSLOT*DW-1:0] dbg_flat
);
    logic [DW-1:0] slot [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (k == int'(CODE_MEM)) begin : g_void
            assign slot[k] = '0;
        end else begin : g_reg
            logic [DW-1:0] q;
            // Hold the register, loading it when selected for write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_sel == RSEL_W'(k))
                    q <= wr_data;
            end
            assign slot[k] = q;
        end
        assign dbg_flat[k*DW +: DW] = slot[k];
    end

    assign rd_data = slot[rd_sel];
    assign hl      = {slot[CODE_H], slot[CODE_L]};
endmodule

// File: rtl/ld8_agen.sv
// Indexed address generator: base plus sign-extended displacement, wrapping
// modulo the address space. Purely combinational.
module ld8_agen #(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] base,
    input  logic [DW-1:0]   disp,
    output logic [2*DW-1:0] ea
);
    assign ea = base + {{DW{disp[DW-1]}}, disp};
endmodule

// File: rtl/ld8_exec_unit.sv
// Byte-serial execution unit for the 8-bit load group.
// Every byte fetch takes two cycles (address, then data); a memory read
// takes two cycles and a store one write cycle. Unsupported bytes set a
// sticky illegal flag and stop the unit. Assumes read data returns one
// cycle after the address and that writes complete at the clock edge.
module ld8_exec_unit
    import ld8_pkg::*;
#(
    parameter int                DW     = 8,
    parameter logic [2*DW-1:0]   IX_RST = 16'h0800,
    parameter logic [2*DW-1:0]   IY_RST = 16'hFFF0
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [2*DW-1:0]     mem_addr,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_we,
    output logic                halted,
    output logic                illegal,
    output logic [2*DW-1:0]     pc_out,
    output logic [NSLOT*DW-1:0] dbg_regs
);
    localparam int AW = 2 * DW;

    fsm_t              state;
    logic              ph;
    logic [AW-1:0]     pc;
    logic              pfx_on;
    logic              pfx_y;
    logic [RSEL_W-1:0] dst_q;
    logic [RSEL_W-1:0] src_q;
    logic [AW-1:0]     ea_q;
    logic              ill_q;
    logic [AW-1:0]     ix_q;
    logic [AW-1:0]     iy_q;

    kind_t             kind;
    logic [RSEL_W-1:0] dec_dst;
    logic [RSEL_W-1:0] dec_src;
    logic              rf_we;
    logic [RSEL_W-1:0] rf_wsel;
    logic [DW-1:0]     rf_wdata;
    logic [RSEL_W-1:0] rf_rsel;
    logic [DW-1:0]     rf_rdata;
    logic [AW-1:0]     hl;
    logic [AW-1:0]     ea_idx;

    ld8_decode u_dec (
        .op     (mem_rdata),
        .pfx_on (pfx_on),
        .kind   (kind),
        .dst    (dec_dst),
        .src    (dec_src)
    );

    ld8_regfile #(.DW(DW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_sel   (rf_wsel),
        .wr_data  (rf_wdata),
        .rd_sel   (rf_rsel),
        .rd_data  (rf_rdata),
        .hl       (hl),
        .dbg_flat (dbg_regs)
    );

    ld8_agen #(.DW(DW)) u_agen (
        .base (pfx_y ? iy_q : ix_q),
        .disp (mem_rdata),
        .ea   (ea_idx)
    );

    // Register-file port steering: moves read a register, other loads take memory data.
    always_comb begin
        rf_we    = ph && ((state == ST_OP && kind == K_MOVE) ||
                          state == ST_IMM || state == ST_RD);
        rf_wsel  = (state == ST_OP) ? dec_dst : dst_q;
        rf_rsel  = (state == ST_OP) ? dec_src : src_q;
        rf_wdata = (state == ST_OP) ? rf_rdata : mem_rdata;
    end

    // Memory address source per state.
    always_comb begin
        case (state)
            ST_RD:   mem_addr = ea_q;
            ST_WR:   mem_addr = hl;
            default: mem_addr = pc;
        endcase
    end

    assign mem_we    = (state == ST_WR);
    assign mem_wdata = rf_rdata;
    assign halted    = (state == ST_HALT);
    assign illegal   = ill_q;
    assign pc_out    = pc;

    // Sequencer: byte phases, program counter, prefix and address latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OP;
            ph     <= 1'b0;
            pc     <= '0;
            pfx_on <= 1'b0;
            pfx_y  <= 1'b0;
            dst_q  <= '0;
            src_q  <= '0;
            ea_q   <= '0;
            ill_q  <= 1'b0;
            ix_q   <= IX_RST;
            iy_q   <= IY_RST;
        end else begin
            case (state)
                ST_OP: begin
                    ph <= !ph;
                    if (ph) begin
                        pc <= pc + AW'(1);
                        case (kind)
                            K_PFX_X: begin pfx_on <= 1'b1; pfx_y <= 1'b0; end
                            K_PFX_Y: begin pfx_on <= 1'b1; pfx_y <= 1'b1; end
                            K_MOVE:  ;
                            K_IMM:   begin dst_q <= dec_dst; state <= ST_IMM; end
                            K_LDHL:  begin dst_q <= dec_dst; ea_q <= hl; state <= ST_RD; end
                            K_STHL:  begin src_q <= dec_src; state <= ST_WR; end
                            K_IDX:   begin dst_q <= dec_dst; state <= ST_DISP; end
                            K_HALT:  state <= ST_HALT;
                            default: begin ill_q <= 1'b1; state <= ST_HALT; end
                        endcase
                    end
                end
                ST_DISP: begin
                    ph <= !ph;
                    if (ph) begin
                        pc     <= pc + AW'(1);
                        ea_q   <= ea_idx;
                        pfx_on <= 1'b0;
                        state  <= ST_RD;
                    end
                end
                ST_IMM: begin
                    ph <= !ph;
                    if (ph) begin
                        pc    <= pc + AW'(1);
                        state <= ST_OP;
                    end
                end
                ST_RD: begin
                    ph <= !ph;
                    if (ph)
                        state <= ST_OP;
                end
                ST_WR:   state <= ST_OP;
                default: state <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/ld8_exec_unit_chk.sv
// Temporal checks on the load unit's ports, attached by bind.
module ld8_exec_unit_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*DW-1:0] mem_addr,
    input logic            mem_we,
    input logic            halted,
    input logic            illegal,
    input logic [2*DW-1:0] pc_out,
    input logic [8*DW-1:0] dbg_regs
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(pc_out)); // R7
    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_we); // R7
    AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted); // R8
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R5
    AST_WE_AT_HL: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_addr == {dbg_regs[4*DW +: DW], dbg_regs[5*DW +: DW]}); // R5
    AST_STORE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> $stable(dbg_regs)); // R5
    AST_PC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pc_out != $past(pc_out)) |-> (pc_out == $past(pc_out) + 16'd1)); // R9
    AST_SLOT_VOID: assert property (@(posedge clk) disable iff (!rst_n) dbg_regs[6*DW +: DW] == '0); // R2
endmodule

bind ld8_exec_unit ld8_exec_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_ld8_exec_unit.sv
module sim_ld8_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        halted;
    logic        illegal;
    logic [15:0] pc_out;
    logic [63:0] dbg_regs;

    always #5 clk = ~clk;

    ld8_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted),
        .illegal(illegal), .pc_out(pc_out), .dbg_regs(dbg_regs)
    );

    // bench memory seen by the design, and the model's private copy
    logic [7:0] bmem [int];
    logic [7:0] mmem [int];
    logic [7:0] prog [$];

    int n_cmp = 0;
    int n_fail = 0;
    bit chk_en = 0;
    bit done = 0;

    logic [15:0] mpc;
    logic [7:0]  mreg [8];
    bit          mhalt, mill, exp_we;
    logic [15:0] exp_wa;
    logic [7:0]  exp_wd;
    string       cur_req = "R1";

    function automatic logic [7:0] bread(input logic [15:0] a);
        return bmem.exists(int'(a)) ? bmem[int'(a)] : 8'h00;
    endfunction
    function automatic logic [7:0] mread(input logic [15:0] a);
        return mmem.exists(int'(a)) ? mmem[int'(a)] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        mem_rdata <= bread(mem_addr);
    end

    function automatic logic [63:0] exp_flat();
        logic [63:0] f;
        for (int k = 0; k < 8; k++) f[k*8 +: 8] = (k == 6) ? 8'h00 : mreg[k];
        return f;
    endfunction

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (chk_en) begin
            bit bad = 0;
            n_cmp++;
            if (pc_out !== mpc) begin
                bad = 1; $display("FAIL R9 pc actual=%h expected=%h", pc_out, mpc);
            end
            if (dbg_regs !== exp_flat()) begin
                bad = 1; $display("FAIL %s regs actual=%h expected=%h", cur_req, dbg_regs, exp_flat());
            end
            if (halted !== mhalt) begin
                bad = 1; $display("FAIL R7 halted actual=%b expected=%b", halted, mhalt);
            end
            if (illegal !== mill) begin
                bad = 1; $display("FAIL R8 illegal actual=%b expected=%b", illegal, mill);
            end
            if (mem_we !== exp_we) begin
                bad = 1; $display("FAIL R5 we actual=%b expected=%b", mem_we, exp_we);
            end else if (exp_we && (mem_addr !== exp_wa || mem_wdata !== exp_wd)) begin
                bad = 1; $display("FAIL R5 write actual=%h/%h expected=%h/%h",
                                  mem_addr, mem_wdata, exp_wa, exp_wd);
            end
            if (bad) n_fail++;
        end
    end

    task automatic fetch(output logic [7:0] b);
        @(posedge clk); @(posedge clk);
        b = mread(mpc);
        mpc = mpc + 16'd1;
    endtask

    task automatic stop(input bit bad);
        mhalt = 1; mill = bad;
    endtask

    // behavioural instruction-level model, advanced in step with the clock
    task automatic model_exec();
        logic [7:0] op, op2, d;
        logic [15:0] base, ea;
        int sd;
        while (!mhalt) begin
            fetch(op);
            if (op == 8'hDD || op == 8'hFD) begin
                cur_req = "R6";
                base = (op == 8'hFD) ? 16'hFFF0 : 16'h0800;
                fetch(op2);
                if (op2[7:6] == 2'b01 && op2[2:0] == 3'b110 && op2[5:3] != 3'b110) begin
                    fetch(d);
                    sd = (d > 127) ? int'(d) - 256 : int'(d);
                    ea = 16'(int'(base) + sd);
                    @(posedge clk); @(posedge clk);
                    mreg[op2[5:3]] = mread(ea);
                end else begin
                    cur_req = "R8"; stop(1);
                end
            end else if (op == 8'h76) begin
                cur_req = "R7"; stop(0);
            end else if (op[7:6] == 2'b01 && op[5:3] == 3'b110) begin
                cur_req = "R5";
                exp_we = 1; exp_wa = {mreg[4], mreg[5]}; exp_wd = mreg[op[2:0]];
                @(posedge clk);
                exp_we = 0; mmem[int'(exp_wa)] = exp_wd;
            end else if (op[7:6] == 2'b01 && op[2:0] == 3'b110) begin
                cur_req = "R4";
                ea = {mreg[4], mreg[5]};
                @(posedge clk); @(posedge clk);
                mreg[op[5:3]] = mread(ea);
            end else if (op[7:6] == 2'b01) begin
                cur_req = "R2";
                mreg[op[5:3]] = mreg[op[2:0]];
            end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110 && op[5:3] != 3'b110) begin
                cur_req = "R3";
                fetch(d);
                mreg[op[5:3]] = d;
            end else begin
                cur_req = "R8"; stop(1);
            end
        end
    endtask

    task automatic put(input int a, input logic [7:0] v);
        bmem[a] = v; mmem[a] = v;
    endtask

    task automatic run_prog(input string name);
        chk_en = 0;
        @(negedge clk);
        rst_n = 0;
        bmem.delete(); mmem.delete();
        foreach (prog[i]) put(i, prog[i]);
        mpc = 16'h0000; mhalt = 0; mill = 0; exp_we = 0;
        for (int k = 0; k < 8; k++) mreg[k] = 8'h00;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (pc_out !== 16'h0000 || dbg_regs !== 64'h0 || halted !== 1'b0 ||
            illegal !== 1'b0 || mem_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 %s reset actual=%h/%h/%b%b%b expected=0000/0/000",
                     name, pc_out, dbg_regs, halted, illegal, mem_we);
        end
        rst_n = 1;
        chk_en = 1;
        model_exec();
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk_en = 0;
    endtask

    initial begin
        // R2, R3: immediates into every register, then moves
        prog = {8'h06, 8'h11, 8'h0E, 8'h22, 8'h16, 8'h33, 8'h1E, 8'h44, 8'h26, 8'h55,
                8'h2E, 8'h66, 8'h3E, 8'h77, 8'h78, 8'h41, 8'h6F, 8'h53, 8'h7F, 8'h76};
        run_prog("moves");
        // R4, R5: H:L reads and stores, including H/L as data and address
        prog = {8'h26, 8'h12, 8'h2E, 8'h34, 8'h7E, 8'h06, 8'h9C, 8'h70, 8'h74, 8'h75,
                8'h46, 8'h66, 8'h4E, 8'h76};
        bmem.delete();
        run_prog_hl();
        // R6: indexed reads, positive/negative/wrapping displacements
        prog = {8'hDD, 8'h7E, 8'h05, 8'hDD, 8'h46, 8'hFB, 8'hFD, 8'h4E, 8'h20,
                8'hFD, 8'h56, 8'h80, 8'hDD, 8'h5E, 8'h7F, 8'h76};
        run_prog_idx();
        // R8: unsupported opcode after valid work
        prog = {8'h3E, 8'h01, 8'h80, 8'h06, 8'h05};
        run_prog("r8_arith");
        prog = {8'hDD, 8'h70};
        run_prog("r8_pfx_store");
        prog = {8'hFD, 8'hDD, 8'h7E, 8'h00};
        run_prog("r8_pfx_pfx");
        prog = {8'h36, 8'h10};
        run_prog("r8_imm_mem");
        prog = {8'hDD, 8'h76};
        run_prog("r8_pfx_halt");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    task automatic run_prog_hl();
        // data seeded through the reset-time load: extend program image first
        for (int i = prog.size(); i < 16'h1235; i++) prog.push_back(8'h00);
        prog[16'h1234] = 8'h5A;
        run_prog_ext("hl", 16'h3434, 8'hE1);
    endtask

    task automatic run_prog_idx();
        for (int i = prog.size(); i < 16'h0880; i++) prog.push_back(8'h00);
        prog[16'h0805] = 8'hA1;
        prog[16'h07FB] = 8'hB2;
        prog[16'h0010] = 8'hC3;
        prog[16'h087F] = 8'hE5;
        run_prog_ext("idx", 16'hFF70, 8'hD4);
    endtask

    task automatic run_prog_ext(input string name, input logic [15:0] xa, input logic [7:0] xv);
        fork
            begin
                @(negedge rst_n);
                put(int'(xa), xv);
            end
            run_prog(name);
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule